// File: doc/BRIEF.md
# Address and Source Request Router

This block is one routing stage of an on-chip interconnect. Each incoming request carries an address, a space flag (I/O or memory) and a source number. The router picks one of several output ports for it and passes the request on through a one-entry registered stage. Each output port has its own valid/ready pair. The request payload itself is not handled here.

Routing follows a fixed priority, highest first:
- Requests from a parameterised set of bus-master sources always go to the upstream bridge port, whatever their address.
- A built-in legacy disk hole, enabled at reset, sends the legacy primary disk-controller I/O addresses to the disk port.
- A small bank of programmable region descriptors is searched next, and the lowest-numbered hit wins.
- Anything left over goes to the default subtractive port, with exactly the same latency as a descriptor hit.

The hole and the descriptors are changed through simple configuration write inputs.

Top module: `req_router`

## Requirements
- R1: After reset the legacy hole is enabled, so an I/O request (req_io=1) from a non-master source to any address 01F0h–01F7h, or to 03F6h, is routed to the disk port (port 2).
- R2: A request that hits neither the hole nor any enabled descriptor is routed to the default port (port 0). This includes memory-space requests (req_io=0) to the hole addresses.
- R3: A hole write with hole_en_in=0 disables the hole, and the legacy addresses then follow the descriptors or the default port. Writing 1 enables it again.
- R4: A descriptor hits when all three of these hold:
  - it is enabled;
  - its space bit equals req_io;
  - (req_addr & mask) == (base & mask).
  A hit routes the request to the descriptor's port field.
- R5: When several descriptors hit, the lowest index wins, and an enabled hole hit takes priority over every descriptor.
- R6: Requests from sources 1 to 5 (MASTER_MASK bits) go to the bridge port (port 1) regardless of address, space, hole or descriptors.
- R7: A request accepted at a clock edge (req_valid and req_ready high) appears from that edge on, with exactly one bit of out_valid set and out_addr equal to req_addr. Every route, including the default, has this same one-cycle latency.
- R8: While the selected port holds out_ready low, out_valid and out_addr stay stable and req_ready is low. The output clears on the edge where that port is ready and no new request is loaded.
- R9: All descriptors are disabled at reset. Writing a descriptor with cfg_en=0 makes it ignored by routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | DIDX_W | Descriptor index to write |
| cfg_en | input | 1 | Descriptor enable value |
| cfg_io | input | 1 | Descriptor space: 1 = I/O, 0 = memory |
| cfg_base | input | ADDR_W | Descriptor base address |
| cfg_mask | input | ADDR_W | Descriptor compare mask |
| cfg_port | input | PORT_W | Descriptor destination port |
| hole_we | input | 1 | Legacy hole write strobe |
| hole_en_in | input | 1 | Legacy hole enable value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Request address |
| req_io | input | 1 | Request space: 1 = I/O, 0 = memory |
| req_src | input | SRC_W | Request source number |
| out_valid | output | NUM_PORTS | Per-port valid, one-hot |
| out_ready | input | NUM_PORTS | Per-port ready |
| out_addr | output | ADDR_W | Forwarded address |
| out_io | output | 1 | Forwarded space flag |
| out_src | output | SRC_W | Forwarded source number |

## Verification
A request driven before edge k and accepted there shows its route on out_valid right after edge k. The bench therefore drives at the falling edge, waits for the accepting rising edge, and compares out_valid and out_addr at the next falling edge.

A configuration write takes effect for requests accepted from the edge after the write. The bench always completes a write one full cycle before the next request.

In the back-pressure case, the output is checked at several falling edges while the port is stalled. It is checked once more one edge after out_ready rises, when it must have cleared.

// File: rtl/rr_pkg.sv
package rr_pkg;
  typedef enum logic {SP_MEM = 1'b0, SP_IO = 1'b1} space_e;
  localparam logic [15:0] HOLE_BLOCK = 16'h01F0;
  localparam logic [15:0] HOLE_SINGLE = 16'h03F6;
endpackage

// File: rtl/rr_desc_bank.sv
module rr_desc_bank #(
  parameter int ADDR_W = 16,
  parameter int NUM_DESC = 4,
  parameter int PORT_W = 2,
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [DIDX_W-1:0]                 cfg_idx,
  input  logic                              cfg_en,
  input  logic                              cfg_io,
  input  logic [ADDR_W-1:0]                 cfg_base,
  input  logic [ADDR_W-1:0]                 cfg_mask,
  input  logic [PORT_W-1:0]                 cfg_port,
  input  logic                              hole_we,
  input  logic                              hole_en_in,
  output logic [NUM_DESC-1:0]               d_en,
  output logic [NUM_DESC-1:0]               d_io,
  output logic [NUM_DESC-1:0][ADDR_W-1:0]   d_base,
  output logic [NUM_DESC-1:0][ADDR_W-1:0]   d_mask,
  output logic [NUM_DESC-1:0][PORT_W-1:0]   d_port,
  output logic                              hole_en
);
  logic hole_d;

  always_comb begin
    hole_d = hole_en;
    if (hole_we) hole_d = hole_en_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hole_en <= 1'b1;
    else        hole_en <= hole_d;
  end

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic wr;
    assign wr = cfg_we && (cfg_idx == DIDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_en[i]   <= 1'b0;
        d_io[i]   <= 1'b0;
        d_base[i] <= '0;
        d_mask[i] <= '0;
        d_port[i] <= '0;
      end else if (wr) begin
        d_en[i]   <= cfg_en;
        d_io[i]   <= cfg_io;
        d_base[i] <= cfg_base;
        d_mask[i] <= cfg_mask;
        d_port[i] <= cfg_port;
      end
    end
  end
endmodule

// File: rtl/rr_match.sv
module rr_match
  import rr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_DESC = 4,
  parameter int PORT_W = 2,
  parameter int SRC_W = 3,
  parameter logic [(1<<SRC_W)-1:0] MASTER_MASK = '0,
  parameter int DEFAULT_PORT = 0,
  parameter int BRIDGE_PORT = 1,
  parameter int DISK_PORT = 2
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              io,
  input  logic [SRC_W-1:0]                  src,
  input  logic [NUM_DESC-1:0]               d_en,
  input  logic [NUM_DESC-1:0]               d_io,
  input  logic [NUM_DESC-1:0][ADDR_W-1:0]   d_base,
  input  logic [NUM_DESC-1:0][ADDR_W-1:0]   d_mask,
  input  logic [NUM_DESC-1:0][PORT_W-1:0]   d_port,
  input  logic                              hole_en,
  output logic [PORT_W-1:0]                 port
);
  localparam logic [ADDR_W-1:0] BLK = ADDR_W'(HOLE_BLOCK);
  localparam logic [ADDR_W-1:0] SGL = ADDR_W'(HOLE_SINGLE);

  logic [NUM_DESC-1:0] hit;
  logic hole_hit;

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_cmp
    assign hit[i] = d_en[i] && (d_io[i] == io) &&
                    ((addr & d_mask[i]) == (d_base[i] & d_mask[i]));
  end

  assign hole_hit = hole_en && (io == SP_IO) &&
                    (((addr >> 3) == (BLK >> 3)) || (addr == SGL));

  always_comb begin
    port = PORT_W'(DEFAULT_PORT);
    for (int i = NUM_DESC - 1; i >= 0; i--) begin
      if (hit[i]) port = d_port[i];
    end
    if (hole_hit) port = PORT_W'(DISK_PORT);
    if (MASTER_MASK[src]) port = PORT_W'(BRIDGE_PORT);
  end
endmodule

// File: rtl/rr_out_stage.sv
module rr_out_stage #(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 2,
  parameter int SRC_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PORT_W-1:0]    in_port,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 in_io,
  input  logic [SRC_W-1:0]     in_src,
  output logic [NUM_PORTS-1:0] out_valid,
  input  logic [NUM_PORTS-1:0] out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_io,
  output logic [SRC_W-1:0]     out_src
);
  logic vld_q, vld_d, load, drain;
  logic [PORT_W-1:0] port_q;

  assign drain    = vld_q && out_ready[port_q];
  assign in_ready = !vld_q || drain;
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load)       vld_d = 1'b1;
    else if (drain) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q   <= '0;
      out_addr <= '0;
      out_io   <= 1'b0;
      out_src  <= '0;
    end else if (load) begin
      port_q   <= in_port;
      out_addr <= in_addr;
      out_io   <= in_io;
      out_src  <= in_src;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++)
      out_valid[p] = vld_q && (port_q == PORT_W'(p));
  end
endmodule

// File: rtl/req_router.sv
module req_router #(
  parameter int ADDR_W = 16,
  parameter int NUM_DESC = 4,
  parameter int NUM_PORTS = 4,
  parameter int SRC_W = 3,
  parameter logic [(1<<SRC_W)-1:0] MASTER_MASK = 8'b0011_1110,
  parameter int DEFAULT_PORT = 0,
  parameter int BRIDGE_PORT = 1,
  parameter int DISK_PORT = 2,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DIDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [DIDX_W-1:0]    cfg_idx,
  input  logic                 cfg_en,
  input  logic                 cfg_io,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [ADDR_W-1:0]    cfg_mask,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic                 hole_we,
  input  logic                 hole_en_in,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_io,
  input  logic [SRC_W-1:0]     req_src,
  output logic [NUM_PORTS-1:0] out_valid,
  input  logic [NUM_PORTS-1:0] out_ready,
  output logic [ADDR_W-1:0]    out_addr,
  output logic                 out_io,
  output logic [SRC_W-1:0]     out_src
);
  logic [NUM_DESC-1:0]             d_en, d_io;
  logic [NUM_DESC-1:0][ADDR_W-1:0] d_base, d_mask;
  logic [NUM_DESC-1:0][PORT_W-1:0] d_port;
  logic                            hole_en;
  logic [PORT_W-1:0]               sel_port;

  rr_desc_bank #(.ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC), .PORT_W(PORT_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_io(cfg_io),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_port(cfg_port),
    .hole_we(hole_we), .hole_en_in(hole_en_in),
    .d_en(d_en), .d_io(d_io), .d_base(d_base), .d_mask(d_mask),
    .d_port(d_port), .hole_en(hole_en)
  );

  rr_match #(
    .ADDR_W(ADDR_W), .NUM_DESC(NUM_DESC), .PORT_W(PORT_W), .SRC_W(SRC_W),
    .MASTER_MASK(MASTER_MASK), .DEFAULT_PORT(DEFAULT_PORT),
    .BRIDGE_PORT(BRIDGE_PORT), .DISK_PORT(DISK_PORT)
  ) u_match (
    .addr(req_addr), .io(req_io), .src(req_src),
    .d_en(d_en), .d_io(d_io), .d_base(d_base), .d_mask(d_mask),
    .d_port(d_port), .hole_en(hole_en), .port(sel_port)
  );

  rr_out_stage #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W),
                 .SRC_W(SRC_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_port(sel_port),
    .in_addr(req_addr), .in_io(req_io), .in_src(req_src),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_io(out_io), .out_src(out_src)
  );
endmodule

// File: rtl/rr_checker.sv
module rr_checker #(
  parameter int ADDR_W = 16,
  parameter int NUM_PORTS = 4,
  parameter int SRC_W = 3,
  parameter logic [(1<<SRC_W)-1:0] MASTER_MASK = '0,
  parameter int BRIDGE_PORT = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [SRC_W-1:0]     req_src,
  input logic [NUM_PORTS-1:0] out_valid,
  input logic [NUM_PORTS-1:0] out_ready,
  input logic [ADDR_W-1:0]    out_addr
);
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_valid));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ($countones(out_valid) == 1 && out_addr == $past(req_addr)));

  a_r6_master: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && MASTER_MASK[req_src]) |=> out_valid[BRIDGE_PORT]);

  a_r8_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |-> !req_ready);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(out_valid & ~out_ready)) |=> ($stable(out_valid) && $stable(out_addr)));
endmodule

bind req_router rr_checker #(
  .ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS), .SRC_W(SRC_W),
  .MASTER_MASK(MASTER_MASK), .BRIDGE_PORT(BRIDGE_PORT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_src(req_src), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/sim_req_router.sv
`timescale 1ns/1ps
module sim_req_router;
  localparam int AW = 16;
  localparam int ND = 4;
  localparam int NP = 4;
  localparam int SW = 3;
  localparam logic [7:0] MM = 8'b0011_1110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_io = 1'b0;
  logic [1:0] cfg_idx = '0, cfg_port = '0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic hole_we = 1'b0, hole_en_in = 1'b0;
  logic req_valid = 1'b0, req_io = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_src = '0;
  logic [NP-1:0] out_valid;
  logic [NP-1:0] out_ready = '1;
  logic [AW-1:0] out_addr;
  logic out_io;
  logic [SW-1:0] out_src;

  int checks = 0, fails = 0;
  bit done = 0;

  logic          m_en [ND];
  logic          m_io [ND];
  logic [AW-1:0] m_base [ND];
  logic [AW-1:0] m_mask [ND];
  int            m_port [ND];
  logic          m_hole;

  always #4 clk = ~clk;

  req_router #(.ADDR_W(AW), .NUM_DESC(ND), .NUM_PORTS(NP), .SRC_W(SW),
               .MASTER_MASK(MM)) u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int model(logic [AW-1:0] a, logic io, int src);
    int p = 0;
    for (int i = ND - 1; i >= 0; i--)
      if (m_en[i] && m_io[i] == io && ((a & m_mask[i]) == (m_base[i] & m_mask[i])))
        p = m_port[i];
    if (m_hole && io && ((a >= 16'h01F0 && a <= 16'h01F7) || a == 16'h03F6)) p = 2;
    if (src >= 1 && src <= 5) p = 1;
    return p;
  endfunction

  task automatic wr_desc(int i, logic en, logic io, logic [AW-1:0] b, logic [AW-1:0] m, int p);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(i); cfg_en = en; cfg_io = io;
    cfg_base = b; cfg_mask = m; cfg_port = 2'(p);
    @(negedge clk);
    cfg_we = 0;
    m_en[i] = en; m_io[i] = io; m_base[i] = b; m_mask[i] = m; m_port[i] = p;
  endtask

  task automatic wr_hole(logic en);
    @(negedge clk);
    hole_we = 1; hole_en_in = en;
    @(negedge clk);
    hole_we = 0;
    m_hole = en;
  endtask

  task automatic send(string req, logic [AW-1:0] a, logic io, int src);
    int e;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_io = io; req_src = 3'(src);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    e = model(a, io, src);
    check(req, 32'(out_valid), 32'(1 << e));
    check("R7", 32'(out_addr), 32'(a));
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_en[i] = 0; m_io[i] = 0; m_base[i] = '0; m_mask[i] = '0; m_port[i] = 0;
    end
    m_hole = 1;
    repeat (3) @(negedge clk);
    check("R7 reset out_valid", 32'(out_valid), 32'h0);
    check("R8 reset req_ready", 32'(req_ready), 32'h1);
    rst_n = 1;
    // R1, R2, R9: hole only, descriptors off after reset
    for (int a = 16'h01E8; a < 16'h0200; a++) send("R1/R2", 16'(a), 1, 0);
    for (int a = 16'h03F0; a < 16'h0400; a++) send("R1/R2", 16'(a), 1, 0);
    for (int a = 16'h01F0; a < 16'h01F8; a++) send("R2 mem", 16'(a), 0, 0);
    send("R2 mem", 16'h03F6, 0, 0);
    // R6: every source to a hole address
    for (int s = 0; s < 8; s++) send("R6", 16'h01F3, 1, s);
    for (int s = 0; s < 8; s++) send("R6", 16'h8123, 0, s);
    // R4, R5: overlapping descriptors
    wr_desc(0, 1, 1, 16'h0400, 16'hFFF0, 3);
    wr_desc(1, 1, 1, 16'h0400, 16'hFF00, 2);
    wr_desc(2, 1, 0, 16'h8000, 16'hF000, 3);
    wr_desc(3, 1, 1, 16'h01F0, 16'hFFF0, 3);
    for (int a = 16'h03F0; a < 16'h0520; a++) send("R4/R5", 16'(a), 1, 0);
    for (int a = 16'h7F00; a < 16'h9100; a += 16) send("R4 mem", 16'(a), 0, 0);
    for (int a = 16'h01E8; a < 16'h0200; a++) send("R5 hole first", 16'(a), 1, 0);
    send("R6 over desc", 16'h0405, 1, 3);
    // R3: disable hole, legacy addresses fall to descriptor 3
    wr_hole(0);
    for (int a = 16'h01F0; a < 16'h01F8; a++) send("R3", 16'(a), 1, 0);
    // R9: disabled descriptor ignored -> default
    wr_desc(3, 0, 1, 16'h01F0, 16'hFFF0, 3);
    for (int a = 16'h01F0; a < 16'h01F8; a++) send("R3/R9", 16'(a), 1, 0);
    send("R3", 16'h03F6, 1, 0);
    wr_hole(1);
    send("R3 re-enable", 16'h01F2, 1, 0);
    send("R3 re-enable", 16'h03F6, 1, 0);
    // R8: back-pressure on default port
    @(negedge clk);
    out_ready = 4'b1110;
    req_valid = 1; req_addr = 16'h0010; req_io = 1; req_src = 0;
    @(negedge clk);
    req_addr = 16'h0020;
    for (int k = 0; k < 3; k++) begin
      check("R8 hold valid", 32'(out_valid), 32'h1);
      check("R8 hold addr", 32'(out_addr), 32'h0010);
      check("R8 ready low", 32'(req_ready), 32'h0);
      @(negedge clk);
    end
    req_valid = 0;
    out_ready = 4'b1111;
    @(negedge clk);
    check("R8 drained", 32'(out_valid), 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule